// File: doc/BRIEF.md
# Stream-fed inference accelerator wrapper

This block puts a small fixed-point compute stage behind a pair of AXI4-Stream ports. One frame is sent on the input stream. Its first beats are coefficients and the beats that follow are operands. A position counter steers each beat into the correct on-chip memory. When the frame is complete, a sequencer triggers the compute stage and waits for it to report that it has finished. The result words are then sent out on the output stream, and the last one is marked.

Each 64-bit word holds four signed 16-bit lanes with 10 fraction bits. Output word j is computed lane by lane. The scale is coefficient word 2j and the offset is coefficient word 2j+1. The scale multiplies operand word j, the product is shifted right arithmetically by the fraction width, and the offset is added. The sum wraps to 16 bits. Incoming beats first go into a small FIFO and the sequencer drains it into the memories. Results go into a second FIFO, and the output port reads from it.

Top module: `axnn_stream_top`

## Requirements
- R1: After reset the input stream is ready (s_tready=1) and the output stream is idle (m_tvalid=0, m_tlast=0).
- R2: Each frame is 12 accepted input beats. Beats 0 to 7 in acceptance order are coefficient words 0 to 7, and beats 8 to 11 are operand words 0 to 3.
- R3: From the cycle after the 12th beat of a frame is accepted, s_tready stays low until the last output beat of that frame is accepted. Output beats are offered only after all 12 input beats have been accepted.
- R4: Output word j (j=0..3) has, in every 16-bit lane l (bits 16l+15:16l), the value ((C[2j].l × X[j].l) >>> 10) + C[2j+1].l. The operands are signed, the shift is arithmetic and the sum is kept modulo 2^16.
- R5: Exactly four output beats are sent per frame, in order j=0..3, and m_tlast is high on the fourth beat only.
- R6: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values on the next cycle.
- R7: The cycle after the fourth output beat is accepted, s_tready is high again and a new frame is processed independently of the previous one.
- R8: s_tlast has no effect. Beats are placed by position only, and stalls on either stream do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 64 | Input stream data (four 16-bit lanes) |
| s_tvalid | input | 1 | Input stream valid |
| s_tready | output | 1 | Input stream ready |
| s_tlast | input | 1 | Input stream last marker (ignored) |
| m_tdata | output | 64 | Output stream data |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |
| m_tlast | output | 1 | Marks the fourth output beat |

## Verification
s_tready depends only on registered state. It falls one cycle after the 12th input handshake, so the bench reads it at the falling edge that follows that handshake. The first result becomes valid seven cycles after the 12th beat: one cycle to copy the beat out of the input FIFO, one for the start pulse, four cycles of compute, and one cycle to move the last result into the output FIFO. The bench does not hard-code this delay. It polls m_tvalid at each falling edge, where all outputs have settled, and checks s_tready on every polled cycle. Output handshakes are taken at the rising edge after a falling edge where both m_tvalid and m_tready are high. The stability checks for a stalled beat compare the values at one falling edge with those at the next.

// File: rtl/axnn_pkg.sv
package axnn_pkg;
  localparam int LANE_W     = 16;
  localparam int LANES      = 4;
  localparam int FRAC       = 10;
  localparam int WORD_W     = LANE_W * LANES;
  localparam int W_BEATS    = 8;
  localparam int X_BEATS    = 4;
  localparam int OUT_BEATS  = X_BEATS;
  localparam int FRAME      = W_BEATS + X_BEATS;
  localparam int FIFO_DEPTH = 4;
  localparam int CNT_W      = $clog2(FRAME + 1);
  localparam int WA_W       = $clog2(W_BEATS);
  localparam int XA_W       = $clog2(X_BEATS);
  localparam int OA_W       = $clog2(OUT_BEATS);

  typedef enum logic [1:0] {
    ST_RECV,
    ST_START,
    ST_WAIT,
    ST_DRAIN
  } ctl_state_t;
endpackage

// File: rtl/axnn_fifo.sv
module axnn_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp;
  logic [AW:0]  rp;

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  assign dout  = mem[rp[AW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
endmodule

// File: rtl/axnn_core.sv
module axnn_core
  import axnn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              w_we,
  input  logic [WA_W-1:0]   w_addr,
  input  logic              x_we,
  input  logic [XA_W-1:0]   x_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data,
  output logic              done
);
  logic [WORD_W-1:0] wmem [W_BEATS];
  logic [WORD_W-1:0] xmem [X_BEATS];
  logic [OA_W-1:0]   idx;
  logic              busy;
  logic [WORD_W-1:0] scale_w;
  logic [WORD_W-1:0] bias_w;
  logic [WORD_W-1:0] opnd_w;
  logic [WORD_W-1:0] word_c;

  always_ff @(posedge clk) begin
    if (w_we) wmem[w_addr] <= wr_data;
    if (x_we) xmem[x_addr] <= wr_data;
  end

  assign scale_w = wmem[WA_W'(2 * idx)];
  assign bias_w  = wmem[WA_W'(2 * idx + 1)];
  assign opnd_w  = xmem[XA_W'(idx)];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [LANE_W-1:0] sc;
    logic signed [LANE_W-1:0] xv;
    logic        [LANE_W-1:0] bi;
    assign sc = scale_w[l*LANE_W +: LANE_W];
    assign xv = opnd_w[l*LANE_W +: LANE_W];
    assign bi = bias_w[l*LANE_W +: LANE_W];
    assign word_c[l*LANE_W +: LANE_W] =
      LANE_W'(((2*LANE_W)'(sc) * (2*LANE_W)'(xv)) >>> FRAC) + bi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      done      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        res_valid <= 1'b1;
        res_data  <= word_c;
        idx       <= idx + 1'b1;
        if (idx == OA_W'(OUT_BEATS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/axnn_ctrl.sv
module axnn_ctrl
  import axnn_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            s_tvalid,
  output logic            s_tready,
  input  logic            in_empty,
  input  logic            in_full,
  output logic            in_push,
  output logic            in_pop,
  output logic            w_we,
  output logic [WA_W-1:0] w_addr,
  output logic            x_we,
  output logic [XA_W-1:0] x_addr,
  output logic            core_start,
  input  logic            core_done,
  input  logic            out_empty,
  input  logic            m_tready,
  output logic            m_tvalid,
  output logic            m_tlast,
  output logic            out_pop
);
  ctl_state_t       state;
  logic [CNT_W-1:0] rx_cnt;
  logic [CNT_W-1:0] cp_cnt;
  logic [OA_W-1:0]  tx_cnt;
  logic             to_coef;
  logic             last_tx;

  assign s_tready   = (state == ST_RECV) && (rx_cnt != CNT_W'(FRAME)) && !in_full;
  assign in_push    = s_tvalid && s_tready;
  assign in_pop     = (state == ST_RECV) && !in_empty && (cp_cnt != CNT_W'(FRAME));
  assign to_coef    = cp_cnt < CNT_W'(W_BEATS);
  assign w_we       = in_pop && to_coef;
  assign x_we       = in_pop && !to_coef;
  assign w_addr     = WA_W'(cp_cnt);
  assign x_addr     = XA_W'(cp_cnt - CNT_W'(W_BEATS));
  assign core_start = (state == ST_START);
  assign m_tvalid   = (state == ST_DRAIN) && !out_empty;
  assign last_tx    = (tx_cnt == OA_W'(OUT_BEATS - 1));
  assign m_tlast    = m_tvalid && last_tx;
  assign out_pop    = m_tvalid && m_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_RECV;
      rx_cnt <= '0;
      cp_cnt <= '0;
      tx_cnt <= '0;
    end else begin
      if (in_push) rx_cnt <= rx_cnt + 1'b1;
      if (in_pop)  cp_cnt <= cp_cnt + 1'b1;
      unique case (state)
        ST_RECV:  if (in_pop && cp_cnt == CNT_W'(FRAME - 1)) state <= ST_START;
        ST_START: state <= ST_WAIT;
        ST_WAIT:  if (core_done) state <= ST_DRAIN;
        ST_DRAIN: begin
          if (out_pop) begin
            tx_cnt <= tx_cnt + 1'b1;
            if (last_tx) begin
              state  <= ST_RECV;
              rx_cnt <= '0;
              cp_cnt <= '0;
              tx_cnt <= '0;
            end
          end
        end
        default:  state <= ST_RECV;
      endcase
    end
  end
endmodule

// File: rtl/axnn_stream_top.sv
module axnn_stream_top
  import axnn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);
  logic              in_push, in_pop, in_empty, in_full;
  logic [WORD_W-1:0] in_dout;
  logic              w_we, x_we;
  logic [WA_W-1:0]   w_addr;
  logic [XA_W-1:0]   x_addr;
  logic              core_start, core_done, res_valid;
  logic [WORD_W-1:0] res_data;
  logic              out_pop, out_empty, out_full_unused;
  logic              unused_tlast;

  // beats are placed by position, the frame marker carries no meaning
  assign unused_tlast = s_tlast;

  axnn_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
    .clk(clk), .rst(rst), .push(in_push), .pop(in_pop), .din(s_tdata),
    .dout(in_dout), .empty(in_empty), .full(in_full)
  );

  axnn_ctrl u_ctrl (
    .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .in_empty(in_empty), .in_full(in_full), .in_push(in_push), .in_pop(in_pop),
    .w_we(w_we), .w_addr(w_addr), .x_we(x_we), .x_addr(x_addr),
    .core_start(core_start), .core_done(core_done), .out_empty(out_empty),
    .m_tready(m_tready), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .out_pop(out_pop)
  );

  axnn_core u_core (
    .clk(clk), .rst(rst), .w_we(w_we), .w_addr(w_addr), .x_we(x_we),
    .x_addr(x_addr), .wr_data(in_dout), .start(core_start),
    .res_valid(res_valid), .res_data(res_data), .done(core_done)
  );

  axnn_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
    .clk(clk), .rst(rst), .push(res_valid), .pop(out_pop), .din(res_data),
    .dout(m_tdata), .empty(out_empty), .full(out_full_unused)
  );
endmodule

// File: rtl/axnn_stream_chk.sv
module axnn_stream_chk
  import axnn_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] s_tdata,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              s_tlast,
  input logic [WORD_W-1:0] m_tdata,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              m_tlast
);
  logic [CNT_W-1:0] icnt;
  logic [OA_W-1:0]  ocnt;
  logic             unused_chk;

  assign unused_chk = ^{s_tdata, s_tlast};

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt <= '0;
      ocnt <= '0;
    end else if (m_tvalid && m_tready && m_tlast) begin
      icnt <= '0;
      ocnt <= '0;
    end else begin
      if (s_tvalid && s_tready) icnt <= icnt + 1'b1;
      if (m_tvalid && m_tready) ocnt <= ocnt + 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (s_tready && !m_tvalid && !m_tlast));

  p_stall_full_r3: assert property (@(posedge clk) disable iff (rst)
    (icnt == CNT_W'(FRAME)) |-> !s_tready);

  p_out_after_frame_r3: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (icnt == CNT_W'(FRAME)));

  p_last_pos_r5: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tlast) |-> (ocnt == OA_W'(OUT_BEATS - 1)));

  p_last_set_r5: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && ocnt == OA_W'(OUT_BEATS - 1)) |-> m_tlast);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  p_reopen_r7: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tready && m_tlast) |=> s_tready);
endmodule

bind axnn_stream_top axnn_stream_chk u_chk (.*);

// File: tb/axnn_stream_top_tb.sv
`timescale 1ns/1ps
module axnn_stream_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic        s_tlast = 1'b0;
  logic [63:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;
  logic        m_tlast;
  int          n_tests = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  axnn_stream_top u_dut (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .s_tlast(s_tlast), .m_tdata(m_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  // frame table: seed, idle cycles between input beats, output ready period, beat carrying s_tlast
  localparam int NF = 4;
  localparam logic [15:0] SEED [NF] = '{16'h0123, 16'h8a5f, 16'h3c01, 16'hf00d};
  localparam int          ISTL [NF] = '{0, 1, 2, 0};
  localparam int          OSTL [NF] = '{0, 1, 3, 2};
  localparam int          TLB  [NF] = '{11, 4, 0, 7};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] gen_word(input logic [15:0] seed, input int b);
    logic [63:0] w;
    for (int l = 0; l < 4; l++)
      w[l*16 +: 16] = 16'(seed * (b*4 + l + 1)) ^ 16'(b * 16'h0101);
    return w;
  endfunction

  function automatic logic [63:0] exp_word(input logic [63:0] fw [12], input int j);
    logic [63:0] r;
    for (int l = 0; l < 4; l++) begin
      longint s, x, b, p;
      s = longint'($signed(fw[2*j][l*16 +: 16]));
      b = longint'($signed(fw[2*j+1][l*16 +: 16]));
      x = longint'($signed(fw[8+j][l*16 +: 16]));
      p = (s * x) >>> 10;
      p = p + b;
      r[l*16 +: 16] = p[15:0];
    end
    return r;
  endfunction

  task automatic run_frame(input logic [63:0] fw [12], input logic [63:0] ex [4],
                           input int tlb, input int ist, input int ost, input string tag);
    logic [63:0] pd;
    logic        pl, pend, busy_ok;
    int          n, cyc;
    // send 12 beats
    for (int b = 0; b < 12; b++) begin
      bit acc;
      s_tvalid = 1'b1;
      s_tdata  = fw[b];
      s_tlast  = (b == tlb);
      acc = 1'b0;
      while (!acc) begin
        acc = s_tready;
        @(negedge clk);
      end
      s_tvalid = 1'b0;
      s_tlast  = 1'b0;
      if (b == 11) chk(s_tready == 1'b0, {"R3 ready low after frame ", tag}, 64'(s_tready), 64'd0);
      for (int k = 0; k < ist && b < 11; k++) @(negedge clk);
    end
    // receive 4 beats
    n = 0; cyc = 0; pend = 1'b0; pd = '0; pl = 1'b0; busy_ok = 1'b1;
    while (n < 4) begin
      if (pend) begin
        chk(m_tvalid && m_tdata == pd && m_tlast == pl, {"R6 hold while stalled ", tag}, m_tdata, pd);
      end
      if (s_tready) busy_ok = 1'b0;
      m_tready = ((cyc % (ost + 1)) == 0);
      cyc++;
      if (m_tvalid && m_tready) begin
        chk(m_tdata == ex[n], {"R4 result word ", tag}, m_tdata, ex[n]);
        chk(m_tlast == (n == 3), {"R5 last marker ", tag}, 64'(m_tlast), 64'(n == 3));
        n++;
        pend = 1'b0;
      end else begin
        pend = m_tvalid;
        pd   = m_tdata;
        pl   = m_tlast;
      end
      @(negedge clk);
    end
    m_tready = 1'b0;
    chk(busy_ok, {"R3 ready held low until drained ", tag}, 64'(busy_ok), 64'd1);
    chk(s_tready == 1'b1 && m_tvalid == 1'b0, {"R7 reopen after last beat ", tag}, 64'(s_tready), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] fw [12];
    logic [63:0] ex [4];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(s_tready == 1'b1, "R1 ready after reset", 64'(s_tready), 64'd1);
    chk(m_tvalid == 1'b0 && m_tlast == 1'b0, "R1 output idle after reset", 64'(m_tvalid), 64'd0);

    // table walk: R4 results, R5 marker, R6 hold, R7 back-to-back, R8 tlast and stall immunity
    for (int f = 0; f < NF; f++) begin
      for (int b = 0; b < 12; b++) fw[b] = gen_word(SEED[f], b);
      for (int j = 0; j < 4; j++) ex[j] = exp_word(fw, j);
      run_frame(fw, ex, TLB[f], ISTL[f], OSTL[f], $sformatf("R8 frame%0d", f));
    end

    // R2 hand vector: unit scale and offset 1 in lanes 0..2, scale -1.0 and offset 0 in lane 3
    for (int j = 0; j < 4; j++) begin
      fw[2*j]   = {16'hFC00, 16'h0400, 16'h0400, 16'h0400};
      fw[2*j+1] = {16'h0000, 16'h0001, 16'h0001, 16'h0001};
      fw[8+j]   = {16'h0003, 16'(16'h0010 + j), 16'(16'h0010 + j), 16'(16'h0010 + j)};
      ex[j]     = {16'hFFFD, 16'(16'h0011 + j), 16'(16'h0011 + j), 16'(16'h0011 + j)};
    end
    run_frame(fw, ex, 3, 0, 0, "R2 position demux");

    // R7 reset in the middle of a frame leaves a clean start
    s_tvalid = 1'b1; s_tdata = 64'hdead_beef_0000_1111;
    repeat (5) @(negedge clk);
    s_tvalid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(s_tready == 1'b1 && m_tvalid == 1'b0, "R1 idle after mid-frame reset", 64'(s_tready), 64'd1);
    for (int b = 0; b < 12; b++) fw[b] = gen_word(16'h5a5a, b);
    for (int j = 0; j < 4; j++) ex[j] = exp_word(fw, j);
    run_frame(fw, ex, 11, 0, 1, "R7 after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule